// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller. Its pins are grouped into banks of 32, and each bank has its own address window of 0x200 bytes. For every pin the block provides the following:

- a synchronised input sample;
- an output value and an output enable;
- a two-bit pad pull request;
- an interrupt detector, which can be set to level or edge, single or both edges, and high/rising or low/falling polarity.

Detected events are kept in a raw status word. A mask word gates the raw status into a masked status word. Software acknowledges events by writing ones to a clear word. All masked status bits, across every bank, are ORed and registered into one interrupt line.

Software reaches the registers through a simple single-cycle request bus:

- A request with `bus_we` high writes a full word. The write takes effect at the clock edge that samples it.
- A request with `bus_we` low is a read. The read word appears on `bus_rdata` one cycle later, with `bus_rvalid` high.

A two-state bus sequencer handles reads:

- `ST_IDLE` moves to `ST_RESP` when a read is accepted.
- `ST_RESP` drives the response. From there it stays in `ST_RESP` if another read arrives, and otherwise returns to `ST_IDLE`.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register is zero. `pin_out`, `pin_oe`, `pad_pull_en`, `pad_pull_up` and `irq` are all low.
- R2: Address decoding works as follows.
  - A read request returns its word on `bus_rdata`, with `bus_rvalid` high, in the cycle after the request.
  - `bus_rvalid` is low in a cycle that follows no read request.
  - Bank n decodes at n*0x200.
  - Pin p is bank p/32, bit p%32.
- R3: Offset 0x04 holds output data and offset 0x08 holds output enable. Both read back as written. They drive `pin_out` and `pin_oe` respectively. Pad outputs change only in the cycle after a write.
- R4: Offset 0x00 returns the pin inputs after a two-flop synchroniser. A read issued 4 or more cycles after an input change reflects the change. Writes to offset 0x00 are ignored.
- R5: Offset 0x38 is pull enable and drives `pad_pull_en`. Offset 0x34 is pull select and drives `pad_pull_up`, where 1 means pull-up and 0 means pull-down. The pull outputs change only after a write.
- R6: In offset 0x0C a bit of 0 selects edge mode. In edge mode, polarity at offset 0x14 chooses the edge: 1 is rising and 0 is falling. The chosen edge sets the raw status bit at offset 0x1C, and the bit stays set until cleared. The opposite edge does not set it.
- R7: A bit of 1 in offset 0x10 makes edge mode trigger on both rising and falling edges.
- R8: In offset 0x0C a bit of 1 selects level mode.
  - The raw bit is 1 while the synchronised input is at the active level, which is high when polarity is 1 and low when polarity is 0.
  - A clear does not remove the bit while the level persists.
  - The bit drops when the input is inactive.
- R9: Offset 0x18 is the mask, where 1 enables a pin. Offset 0x20 reads raw AND mask. `irq` is the registered OR of all masked bits in all banks.
- R10: Writing 1 to a bit of offset 0x24 clears that raw edge bit. Writing 0 leaves it unchanged. When a new edge and a clear of the same bit fall in the same cycle, the bit stays set.
- R11: Reads of unimplemented offsets or unpopulated banks return zero, and writes to them change nothing. Bits of pins at or above `PIN_COUNT` read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus request strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address: bank in the upper bits, offset in bits 8:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when `bus_rvalid` is high |
| bus_rvalid | output | 1 | Read response strobe |
| pin_in | input | PIN_COUNT | Asynchronous pin inputs |
| pin_out | output | PIN_COUNT | Output data per pin |
| pin_oe | output | PIN_COUNT | Output enable per pin |
| pad_pull_en | output | PIN_COUNT | Pull resistor enable per pin |
| pad_pull_up | output | PIN_COUNT | Pull direction per pin, 1 up, 0 down |
| irq | output | 1 | Aggregated interrupt |

## Verification
Separate pins of bank 0 are set to each interrupt sense:

- Rising edge and falling edge. Each is driven through both transitions, which shows that the opposite edge is ignored and that the status is sticky.
- Dual edge. This is hit on both transitions.
- High level. This is cleared while still active, which separates level behaviour from a latched edge.
- Masked-off edge. This shows raw status without masked status or `irq`.

A rising edge timed into the same cycle as its clear tells the edge-wins ordering apart from clear-wins. Input words written to both banks, an all-ones write to the part-populated bank, and accesses to an unused offset and to an unpopulated bank address together check bank decoding, pin trimming and aliasing.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int BANK_PINS = 32;
    localparam int OFF_W     = 9;

    localparam logic [OFF_W-1:0] OFF_DIN   = 9'h000;
    localparam logic [OFF_W-1:0] OFF_DOUT  = 9'h004;
    localparam logic [OFF_W-1:0] OFF_OE    = 9'h008;
    localparam logic [OFF_W-1:0] OFF_TYPE  = 9'h00C;
    localparam logic [OFF_W-1:0] OFF_DUAL  = 9'h010;
    localparam logic [OFF_W-1:0] OFF_POL   = 9'h014;
    localparam logic [OFF_W-1:0] OFF_MASK  = 9'h018;
    localparam logic [OFF_W-1:0] OFF_RAW   = 9'h01C;
    localparam logic [OFF_W-1:0] OFF_MSTAT = 9'h020;
    localparam logic [OFF_W-1:0] OFF_CLR   = 9'h024;
    localparam logic [OFF_W-1:0] OFF_PSEL  = 9'h034;
    localparam logic [OFF_W-1:0] OFF_PEN   = 9'h038;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int VALID = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [OFF_W-1:0]     off,
    input  logic [31:0]          wdata,
    input  logic [31:0]          pin_sync,
    output logic [31:0]          rd_data,
    output logic [31:0]          dout,
    output logic [31:0]          oe,
    output logic [31:0]          pull_en,
    output logic [31:0]          pull_sel,
    output logic                 irq_any
);
    localparam logic [31:0] VMASK = 32'((64'd1 << VALID) - 64'd1);

    logic [31:0] itype, dual, pol, mask, raw, prev;
    logic [31:0] rise, fall, edge_hit, lvl_act, clr_vec, raw_d, s_in;

    assign s_in = pin_sync & VMASK;

    always_comb begin
        clr_vec  = (wr_en && off == OFF_CLR) ? (wdata & VMASK) : '0;
        rise     = s_in & ~prev;
        fall     = ~s_in & prev;
        edge_hit = (dual & (rise | fall))
                 | (~dual & pol & rise)
                 | (~dual & ~pol & fall);
        lvl_act  = (pol & s_in) | (~pol & ~s_in);
        raw_d    = ((itype & lvl_act) | (~itype & ((raw & ~clr_vec) | edge_hit))) & VMASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout     <= '0;
            oe       <= '0;
            itype    <= '0;
            dual     <= '0;
            pol      <= '0;
            mask     <= '0;
            pull_en  <= '0;
            pull_sel <= '0;
            raw      <= '0;
            prev     <= '0;
        end else begin
            prev <= s_in;
            raw  <= raw_d;
            if (wr_en) begin
                unique case (off)
                    OFF_DOUT: dout     <= wdata & VMASK;
                    OFF_OE:   oe       <= wdata & VMASK;
                    OFF_TYPE: itype    <= wdata & VMASK;
                    OFF_DUAL: dual     <= wdata & VMASK;
                    OFF_POL:  pol      <= wdata & VMASK;
                    OFF_MASK: mask     <= wdata & VMASK;
                    OFF_PSEL: pull_sel <= wdata & VMASK;
                    OFF_PEN:  pull_en  <= wdata & VMASK;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (off)
            OFF_DIN:   rd_data = s_in;
            OFF_DOUT:  rd_data = dout;
            OFF_OE:    rd_data = oe;
            OFF_TYPE:  rd_data = itype;
            OFF_DUAL:  rd_data = dual;
            OFF_POL:   rd_data = pol;
            OFF_MASK:  rd_data = mask;
            OFF_RAW:   rd_data = raw;
            OFF_MSTAT: rd_data = raw & mask;
            OFF_PSEL:  rd_data = pull_sel;
            OFF_PEN:   rd_data = pull_en;
            default:   rd_data = '0;
        endcase
    end

    assign irq_any = |(raw & mask);
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int PIN_COUNT = 40,
    parameter int ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic [PIN_COUNT-1:0] pad_pull_en,
    output logic [PIN_COUNT-1:0] pad_pull_up,
    output logic                 irq
);
    localparam int NUM_BANKS = (PIN_COUNT + BANK_PINS - 1) / BANK_PINS;
    localparam int TOTAL     = NUM_BANKS * BANK_PINS;
    localparam int BANK_W    = ADDR_W - OFF_W;

    bus_state_t state_q, state_d;

    logic [OFF_W-1:0]  offset;
    logic [BANK_W-1:0] bank_sel;
    logic              rd_acc;
    logic [31:0]       read_word;
    logic [31:0]       rdata_q;

    logic [PIN_COUNT-1:0] pin_sync;
    logic [TOTAL-1:0]     sync_full, dout_full, oe_full, pen_full, psel_full;
    logic [31:0]          bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_irq;

    assign offset   = bus_addr[OFF_W-1:0];
    assign bank_sel = bus_addr[ADDR_W-1:OFF_W];
    assign rd_acc   = bus_req && !bus_we;

    gpio_sync #(.WIDTH(PIN_COUNT)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    assign sync_full = TOTAL'(pin_sync);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int VALID = (PIN_COUNT - b * BANK_PINS) >= BANK_PINS ?
                               BANK_PINS : (PIN_COUNT - b * BANK_PINS);
        logic wr_en;
        assign wr_en = bus_req && bus_we && (bank_sel == BANK_W'(b));

        gpio_bank #(.VALID(VALID)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .off      (offset),
            .wdata    (bus_wdata),
            .pin_sync (sync_full[b*BANK_PINS +: BANK_PINS]),
            .rd_data  (bank_rd[b]),
            .dout     (dout_full[b*BANK_PINS +: BANK_PINS]),
            .oe       (oe_full[b*BANK_PINS +: BANK_PINS]),
            .pull_en  (pen_full[b*BANK_PINS +: BANK_PINS]),
            .pull_sel (psel_full[b*BANK_PINS +: BANK_PINS]),
            .irq_any  (bank_irq[b])
        );
    end

    assign pin_out     = dout_full[PIN_COUNT-1:0];
    assign pin_oe      = oe_full[PIN_COUNT-1:0];
    assign pad_pull_en = pen_full[PIN_COUNT-1:0];
    assign pad_pull_up = psel_full[PIN_COUNT-1:0];

    if (TOTAL > PIN_COUNT) begin : g_trim
        logic unused_hi;
        assign unused_hi = ^{dout_full[TOTAL-1:PIN_COUNT], oe_full[TOTAL-1:PIN_COUNT],
                             pen_full[TOTAL-1:PIN_COUNT], psel_full[TOTAL-1:PIN_COUNT]};
    end

    always_comb begin
        read_word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_sel == BANK_W'(b)) read_word = bank_rd[b];
        end
    end

    // bus sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = rd_acc ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_acc ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // bus sequencer: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            irq     <= 1'b0;
        end else begin
            irq <= |bank_irq;
            if (rd_acc) rdata_q <= read_word;
        end
    end

    assign bus_rvalid = (state_q == ST_RESP);
    assign bus_rdata  = rdata_q;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
    parameter int PIN_COUNT = 40,
    parameter int ADDR_W    = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_req,
    input logic                 bus_we,
    input logic [ADDR_W-10:0]   bank_sel,
    input logic [31:0]          bus_rdata,
    input logic                 bus_rvalid,
    input logic [PIN_COUNT-1:0] pin_out,
    input logic [PIN_COUNT-1:0] pin_oe,
    input logic [PIN_COUNT-1:0] pad_pull_en,
    input logic [PIN_COUNT-1:0] pad_pull_up
);
    localparam int NUM_BANKS = (PIN_COUNT + 31) / 32;

    assert_read_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    assert_no_stray_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !bus_rvalid);

    assert_pad_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pin_out) || !$stable(pin_oe)) |-> $past(bus_req && bus_we));

    assert_pull_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pad_pull_en) || !$stable(pad_pull_up)) |-> $past(bus_req && bus_we));

    assert_empty_bank_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && (int'(bank_sel) >= NUM_BANKS)) |=> (bus_rdata == 32'h0));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bank_sel    (bank_sel),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .pad_pull_en (pad_pull_en),
    .pad_pull_up (pad_pull_up)
);

// File: tb/tb_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_bank_ctrl;
    localparam int PIN_COUNT = 40;
    localparam int ADDR_W    = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [PIN_COUNT-1:0] pin_in = '0;
    logic [PIN_COUNT-1:0] pin_out, pin_oe, pad_pull_en, pad_pull_up;
    logic              irq;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] exp;
        logic [31:0] msk;
        string       tag;
    } rd_item_t;

    rd_item_t sb_q[$];

    always #4 clk = ~clk;

    gpio_bank_ctrl #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
        .irq(irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e,
                      input logic [31:0] m, input string tag);
        rd_item_t it;
        it.exp = e; it.msk = m; it.tag = tag;
        sb_q.push_back(it);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    // monitor: compares each read response with the queued expectation
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2 unexpected response actual=%h expected=none", bus_rdata);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                check(it.tag, 64'(bus_rdata & it.msk), 64'(it.exp & it.msk));
            end
        end
    end

    initial begin
        #(200000 * 8);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    localparam logic [ADDR_W-1:0] B1 = 12'h200;
    localparam logic [31:0] ALL = 32'hFFFF_FFFF;

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        check("R1 pin_oe", 64'(pin_oe), 64'h0);
        check("R1 pin_out", 64'(pin_out), 64'h0);
        check("R1 pulls", 64'({pad_pull_en, pad_pull_up}), 64'h0);
        check("R1 irq", 64'(irq), 64'h0);
        rd(12'h008, 32'h0, ALL, "R1 oe reg");
        rd(12'h018, 32'h0, ALL, "R1 mask reg");

        // R3 output data and enable
        wr(12'h004, 32'hA5A5_0001);
        rd(12'h004, 32'hA5A5_0001, ALL, "R3 dout readback");
        check("R3 pin_out low bank", 64'(pin_out[31:0]), 64'hA5A5_0001);
        // R11 R2 bank 1 trims to 8 pins
        wr(B1 | 12'h008, ALL);
        rd(B1 | 12'h008, 32'h0000_00FF, ALL, "R11 oe bank1 trimmed");
        check("R2 pin_oe bank1", 64'(pin_oe), 64'hFF_0000_0000);

        // R4 synchronised input
        pin_in = 40'h5A_1234_5678;
        tick(5);
        rd(12'h000, 32'h1234_5678, ALL, "R4 din bank0");
        rd(B1 | 12'h000, 32'h0000_005A, ALL, "R4 din bank1");
        wr(12'h000, 32'h0);
        rd(12'h000, 32'h1234_5678, ALL, "R4 din write ignored");
        pin_in = '0;
        tick(5);

        // R5 pulls
        wr(12'h038, 32'h0000_00F0);
        wr(12'h034, 32'h0000_0030);
        tick(1);
        check("R5 pull_en", 64'(pad_pull_en), 64'hF0);
        check("R5 pull_up", 64'(pad_pull_up), 64'h30);

        // interrupt configuration in bank 0
        wr(12'h00C, 32'h0000_0040);   // pin6 level
        wr(12'h010, 32'h0000_0020);   // pin5 dual
        wr(12'h014, 32'h0000_0148);   // pins 3,6,8 high/rising
        wr(12'h018, 32'h0000_0178);   // mask 3,4,5,6,8
        wr(12'h024, ALL);
        wr(B1 | 12'h024, ALL);
        tick(2);
        rd(12'h020, 32'h0, ALL, "R9 masked clear");
        tick(1);
        check("R9 irq idle", 64'(irq), 64'h0);

        // R6 rising on pin3
        pin_in[3] = 1'b1; tick(6);
        rd(12'h01C, 32'h8, 32'h8, "R6 rising sets raw");
        rd(12'h020, 32'h8, 32'h8, "R9 masked follows raw");
        check("R9 irq raised", 64'(irq), 64'h1);
        pin_in[3] = 1'b0; tick(6);
        rd(12'h01C, 32'h8, 32'h8, "R6 sticky after fall");
        wr(12'h024, 32'h0); tick(2);
        rd(12'h01C, 32'h8, 32'h8, "R10 zero write no effect");
        wr(12'h024, 32'h8); tick(3);
        rd(12'h01C, 32'h0, 32'h8, "R10 clear one");
        tick(1);
        check("R9 irq after clear", 64'(irq), 64'h0);

        // R6 falling on pin4
        pin_in[4] = 1'b1; tick(6);
        rd(12'h01C, 32'h0, 32'h10, "R6 rise ignored in falling mode");
        pin_in[4] = 1'b0; tick(6);
        rd(12'h01C, 32'h10, 32'h10, "R6 falling sets raw");
        wr(12'h024, 32'h10);

        // R7 dual edge on pin5
        pin_in[5] = 1'b1; tick(6);
        rd(12'h01C, 32'h20, 32'h20, "R7 dual rise");
        wr(12'h024, 32'h20); tick(2);
        rd(12'h01C, 32'h0, 32'h20, "R7 cleared");
        pin_in[5] = 1'b0; tick(6);
        rd(12'h01C, 32'h20, 32'h20, "R7 dual fall");
        wr(12'h024, 32'h20); tick(3);

        // R8 level high on pin6
        pin_in[6] = 1'b1; tick(6);
        rd(12'h01C, 32'h40, 32'h40, "R8 level active");
        wr(12'h024, 32'h40); tick(3);
        rd(12'h01C, 32'h40, 32'h40, "R8 level persists after clear");
        tick(1);
        check("R8 irq while level", 64'(irq), 64'h1);
        pin_in[6] = 1'b0; tick(6);
        rd(12'h01C, 32'h0, 32'h40, "R8 level drops");
        tick(1);
        check("R8 irq after level", 64'(irq), 64'h0);

        // R9 masked-off pin7
        pin_in[7] = 1'b1; tick(2);
        pin_in[7] = 1'b0; tick(6);
        rd(12'h01C, 32'h80, 32'h80, "R9 raw without mask");
        rd(12'h020, 32'h0, 32'h80, "R9 masked stays low");
        tick(1);
        check("R9 irq masked off", 64'(irq), 64'h0);
        wr(12'h024, 32'h80); tick(2);

        // R10 new edge and clear in the same cycle
        pin_in[8] = 1'b1;
        tick(2);
        wr(12'h024, 32'h100);
        tick(3);
        rd(12'h01C, 32'h100, 32'h100, "R10 edge wins over clear");
        wr(12'h024, 32'h100); tick(2);
        rd(12'h01C, 32'h0, 32'h100, "R10 later clear");

        // R11 unimplemented offset and bank
        wr(12'h028, ALL);
        rd(12'h028, 32'h0, ALL, "R11 unused offset");
        wr(12'h404, 32'h0);
        rd(12'h404, 32'h0, ALL, "R11 empty bank");
        rd(12'h004, 32'hA5A5_0001, ALL, "R11 no alias to bank0");
        tick(4);

        check("R2 all responses seen", 64'(sb_q.size()), 64'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule